// File: doc/BRIEF.md
# Byte-Mask Load/Store Overlap Detector

This block keeps a small set of slots for loads and stores that are in flight. For every occupied slot it reports whether that access can be issued alongside all the other occupied accesses without touching a shared byte. It does not compare full addresses. Each slot keeps a partial tag and a byte bitmap. The tag is the address bits above the granule offset and below the page boundary. The bitmap covers one granule and is built from the offset and the access size. An access that runs past the end of its granule also keeps a second bitmap. That second bitmap belongs to the next granule, at tag plus one.

The check is conservative. Two accesses whose partial addresses alias are reported as a clash even if their full addresses differ. That costs only some parallelism. A real overlap is never reported as clash-free. A scheduler sets a slot's allocate strobe with the address and size on the same cycle, and pulses the release strobe when the access retires. It then reads the per-slot clear flags and the pairwise no-match matrix in the cycle after each change.

Top module: `lsov_top`

## Requirements
- R1: After reset no slot is occupied, and every bit of `noClashO` and `noMatchO` is 0.
- R2: A slot is occupied from the cycle after its allocate strobe, and free from the cycle after its release strobe. Asserting both strobes on one edge leaves the slot free. An allocate on an occupied slot replaces its address and size.
- R3: The size code selects the access length: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The access covers the bytes from its address upward.
- R4: Two occupied accesses in the same granule whose byte ranges do not intersect are reported as not matching.
- R5: Two occupied accesses with at least one common byte are reported as matching, and both of their `noClashO` bits are 0.
- R6: Accesses in different granules, with no spill reaching the other granule, do not match.
- R7: Bytes past the end of a granule are compared against the next granule. This also holds across the wrap from the top of the partial address space to granule 0.
- R8: A slot never matches itself. A lone occupied slot has `noClashO` 1 and its diagonal `noMatchO` bit 1.
- R9: A free slot has an all-zero row and column in `noMatchO` and `noClashO` 0. Its stored address causes no clash for any other slot.
- R10: `noMatchO[i][j]` equals `noMatchO[j][i]`. `noClashO[i]` is 1 exactly when slot i is occupied and matches no other occupied slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| slotSetI | input | NUM_SLOTS | Per-slot allocate strobe; captures address and size |
| slotClrI | input | NUM_SLOTS | Per-slot release strobe; wins over allocate |
| slotAddrI | input | NUM_SLOTS x ADDR_W | Per-slot partial byte address |
| slotSizeI | input | NUM_SLOTS x 2 | Per-slot size code (R3) |
| noClashO | output | NUM_SLOTS | Slot occupied and overlapping no other occupied slot |
| noMatchO | output | NUM_SLOTS x NUM_SLOTS | Row i, bit j: both occupied and no overlap (diagonal: occupied) |

## Verification
The stored tag, bitmap, spill bitmap and occupancy flag all feed the outputs combinationally. A corrupted field therefore shows up in the first cycle after the capturing edge, and it shows up only in the rows and columns of pairs that involve the slot. The bench places second accesses on chosen byte boundaries: just inside, just outside, before the granule edge and after it. That way a mask shifted or sized wrongly by one byte flips a matrix bit. A flag that stays stuck after release makes the row of a freed slot non-zero at once.

// File: rtl/lsov_pkg.sv
package lsov_pkg;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } accSize_e;

  typedef struct packed {
    logic capture;
    logic occupied;
  } slotStrobe_t;

endpackage

// File: rtl/lsov_ctrl.sv
module lsov_ctrl
  import lsov_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic        [NUM_SLOTS-1:0]   setStb,
  input  logic        [NUM_SLOTS-1:0]   clrStb,
  output slotStrobe_t [NUM_SLOTS-1:0]   strobes
);

  logic [NUM_SLOTS-1:0] occQ;

  // release wins over allocate
  always_ff @(posedge clk) begin
    if (!rstN) occQ <= '0;
    else       occQ <= (occQ | setStb) & ~clrStb;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_strobe
    assign strobes[s].capture  = setStb[s] & ~clrStb[s];
    assign strobes[s].occupied = occQ[s];

    a_r2_release_frees : assert property (@(posedge clk) disable iff (!rstN)
      clrStb[s] |=> !occQ[s]);
    a_r2_alloc_holds : assert property (@(posedge clk) disable iff (!rstN)
      (setStb[s] && !clrStb[s]) |=> occQ[s]);
    a_r2_idle_keeps : assert property (@(posedge clk) disable iff (!rstN)
      (!setStb[s] && !clrStb[s]) |=> $stable(occQ[s]));
  end

endmodule

// File: rtl/lsov_datapath.sv
module lsov_datapath
  import lsov_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 12,
  parameter int GRAN_BITS = 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic        [NUM_SLOTS-1:0][ADDR_W-1:0] addrIn,
  input  logic        [NUM_SLOTS-1:0][1:0]      sizeIn,
  input  slotStrobe_t [NUM_SLOTS-1:0]           strobes,
  output logic        [NUM_SLOTS-1:0][NUM_SLOTS-1:0] noMatchO,
  output logic        [NUM_SLOTS-1:0]           noClashO
);

  localparam int GRAN_BYTES = 1 << GRAN_BITS;
  localparam int RUN_W      = 2 * GRAN_BYTES;
  localparam int TAG_W      = ADDR_W - GRAN_BITS;
  localparam logic [RUN_W-1:0] RUN_ONE = 1;
  localparam logic [TAG_W-1:0] TAG_ONE = 1;

  logic [NUM_SLOTS-1:0][TAG_W-1:0]      tagQ;
  logic [NUM_SLOTS-1:0][TAG_W-1:0]      nextTag;
  logic [NUM_SLOTS-1:0][GRAN_BYTES-1:0] primQ;
  logic [NUM_SLOTS-1:0][GRAN_BYTES-1:0] spillQ;
  logic [NUM_SLOTS-1:0]                 occVec;
  logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0]  hit;

  // per-slot mask build and capture
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [3:0]       byteCount;
    logic [RUN_W-1:0] run;

    always_comb begin
      byteCount = 4'd1 << sizeIn[s];
      run = ((RUN_ONE << byteCount) - RUN_ONE) << addrIn[s][GRAN_BITS-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tagQ[s]   <= '0;
        primQ[s]  <= '0;
        spillQ[s] <= '0;
      end else if (strobes[s].capture) begin
        tagQ[s]   <= addrIn[s][ADDR_W-1:GRAN_BITS];
        primQ[s]  <= run[GRAN_BYTES-1:0];
        spillQ[s] <= run[RUN_W-1:GRAN_BYTES];
      end
    end

    assign nextTag[s] = tagQ[s] + TAG_ONE;
    assign occVec[s]  = strobes[s].occupied;

    a_r3_mask_bytes : assert property (@(posedge clk) disable iff (!rstN)
      strobes[s].capture |=>
        $countones({spillQ[s], primQ[s]}) == (32'd1 << $past(sizeIn[s])));
    a_r7_spill_flag : assert property (@(posedge clk) disable iff (!rstN)
      strobes[s].capture |=>
        ((|spillQ[s]) == ((32'($past(addrIn[s][GRAN_BITS-1:0]))
                           + (32'd1 << $past(sizeIn[s]))) > GRAN_BYTES)));
    a_r9_free_row_zero : assert property (@(posedge clk) disable iff (!rstN)
      !strobes[s].occupied |-> (noMatchO[s] == '0 && !noClashO[s]));
  end

  // pairwise overlap
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_row
    for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_col
      if (i == j) begin : g_self
        assign hit[i][j]      = 1'b0;
        assign noMatchO[i][j] = occVec[i];
      end else begin : g_pair
        assign hit[i][j] =
            ((tagQ[i] == tagQ[j])    && |(primQ[i]  & primQ[j]))  ||
            ((tagQ[i] == tagQ[j])    && |(spillQ[i] & spillQ[j])) ||
            ((nextTag[i] == tagQ[j]) && |(spillQ[i] & primQ[j]))  ||
            ((nextTag[j] == tagQ[i]) && |(spillQ[j] & primQ[i]));
        assign noMatchO[i][j] = occVec[i] & occVec[j] & ~hit[i][j];

        a_r10_symmetric : assert property (@(posedge clk) disable iff (!rstN)
          noMatchO[i][j] == noMatchO[j][i]);
      end
    end
    assign noClashO[i] = occVec[i] & (&(noMatchO[i] | ~occVec));
  end

endmodule

// File: rtl/lsov_top.sv
module lsov_top
  import lsov_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 12,
  parameter int GRAN_BITS = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_SLOTS-1:0]                   slotSetI,
  input  logic [NUM_SLOTS-1:0]                   slotClrI,
  input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]       slotAddrI,
  input  logic [NUM_SLOTS-1:0][1:0]              slotSizeI,
  output logic [NUM_SLOTS-1:0]                   noClashO,
  output logic [NUM_SLOTS-1:0][NUM_SLOTS-1:0]    noMatchO
);

  slotStrobe_t [NUM_SLOTS-1:0] strobes;

  lsov_ctrl #(.NUM_SLOTS(NUM_SLOTS)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .setStb  (slotSetI),
    .clrStb  (slotClrI),
    .strobes (strobes)
  );

  lsov_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .GRAN_BITS (GRAN_BITS)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .addrIn   (slotAddrI),
    .sizeIn   (slotSizeI),
    .strobes  (strobes),
    .noMatchO (noMatchO),
    .noClashO (noClashO)
  );

endmodule

// File: tb/test_lsov_top.sv
module test_lsov_top;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int AW         = 12;
  localparam int SPACE      = 1 << AW;

  typedef struct {
    logic [N-1:0]        clash;
    logic [N-1:0][N-1:0] mat;
    string               req;
  } expItem_t;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic [N-1:0]           slotSetI = '0;
  logic [N-1:0]           slotClrI = '0;
  logic [N-1:0][AW-1:0]   slotAddrI = '0;
  logic [N-1:0][1:0]      slotSizeI = '0;
  logic [N-1:0]           noClashO;
  logic [N-1:0][N-1:0]    noMatchO;

  int compared = 0;
  int mismatched = 0;
  expItem_t expQ[$];

  int  mAddr[N];
  int  mSize[N];
  bit  mOcc[N];

  lsov_top #(.NUM_SLOTS(N), .ADDR_W(AW), .GRAN_BITS(4)) i_lsov_top (
    .clk(clk), .rstN(rstN), .slotSetI(slotSetI), .slotClrI(slotClrI),
    .slotAddrI(slotAddrI), .slotSizeI(slotSizeI),
    .noClashO(noClashO), .noMatchO(noMatchO)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // byte-enumeration model of overlap
  function automatic bit overlaps(int a, int sa, int b, int sb);
    for (int k = 0; k < (1 << sa); k++)
      for (int l = 0; l < (1 << sb); l++)
        if (((a + k) % SPACE) == ((b + l) % SPACE)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic push_expect(string req);
    expItem_t it;
    it.req = req;
    for (int i = 0; i < N; i++) begin
      it.clash[i] = mOcc[i];
      for (int j = 0; j < N; j++) begin
        if (i == j) it.mat[i][j] = mOcc[i];
        else begin
          it.mat[i][j] = mOcc[i] && mOcc[j] &&
                         !overlaps(mAddr[i], mSize[i], mAddr[j], mSize[j]);
          if (mOcc[j] && !it.mat[i][j]) it.clash[i] = 1'b0;
        end
      end
    end
    expQ.push_back(it);
  endtask

  // one edge of strobes, then wait to the next falling edge
  task automatic strobe(int s, bit setB, bit clrB, int a, int sz, string req);
    @(negedge clk);
    slotSetI[s] = setB;
    slotClrI[s] = clrB;
    slotAddrI[s] = AW'(a);
    slotSizeI[s] = 2'(sz);
    @(posedge clk);
    if (clrB) mOcc[s] = 1'b0;
    else if (setB) begin
      mOcc[s] = 1'b1; mAddr[s] = a; mSize[s] = sz;
    end
    @(negedge clk);
    slotSetI = '0;
    slotClrI = '0;
    push_expect(req);
  endtask

  task automatic load(int s, int a, int sz, string req);
    strobe(s, 1'b1, 1'b0, a, sz, req);
  endtask

  task automatic free(int s, string req);
    strobe(s, 1'b0, 1'b1, 0, 0, req);
  endtask

  // monitor: pops expectations and compares against the ports
  initial begin
    expItem_t it;
    forever begin
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      compared++;
      if (noClashO !== it.clash) begin
        mismatched++;
        $display("FAIL %s noClashO actual=%b expected=%b", it.req, noClashO, it.clash);
      end
      compared++;
      if (noMatchO !== it.mat) begin
        mismatched++;
        $display("FAIL %s noMatchO actual=%h expected=%h", it.req, noMatchO, it.mat);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mOcc[i] = 0; mAddr[i] = 0; mSize[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    push_expect("R1 reset state");

    load(0, 'h100, 3, "R8 lone slot");                 // 0x100-0x107
    load(1, 'h108, 3, "R4 same tag disjoint");          // 0x108-0x10F
    load(2, 'h104, 1, "R5 same tag overlap");           // 0x104-0x105
    free(2, "R2 release");
    load(2, 'h200, 3, "R6 different tags");
    load(3, 'h20C, 3, "R7 spill no partner");           // 0x20C-0x213
    load(1, 'h210, 0, "R7 spill hits next granule");
    load(1, 'h214, 2, "R7 spill just past end");
    load(1, 'h107, 0, "R3 byte last of dword");
    load(1, 'h108, 0, "R3 byte just after dword");
    load(1, 'h10E, 1, "R3 half at granule top");
    load(1, 'h106, 1, "R3 half inside dword");
    load(1, 'h0FE, 2, "R7 spill from previous granule");
    load(1, 'h0FC, 2, "R3 word ends before granule");
    load(1, 'h104, 3, "R10 overlap with slot0 only");
    free(0, "R9 freed slot masked");
    strobe(0, 1'b1, 1'b1, 'h104, 3, "R2 release wins over allocate");
    load(2, 'hFFC, 3, "R7 wrap setup");                 // 0xFFC-0x1003
    load(0, 'h002, 0, "R7 wrap across top");
    load(0, 'h004, 0, "R7 wrap just past spill");
    free(3, "R9 free spill slot");
    load(3, 'h20C, 3, "R2 reallocate slot");

    wait (expQ.size() == 0);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule